// File: doc/BRIEF.md
# Single-Bit Register with Mode-Steered Asynchronous Controls

This block is the storage bit of a programmable logic cell. A single physical flop with a true asynchronous set and a true asynchronous reset is wrapped by a small steering stage. A static 3-bit mode input decides how two shared active-high control lines, `ac_a` and `ac_b`, and an auxiliary value `ld_val` reach that flop's set and reset pins. It also decides whether the flop works with an inverted data input and an inverted output. With that inversion, a physical clear appears at the output as a preset.

With no asynchronous action active, the block is an ordinary clock-enabled register with a synchronous active-high reset. An asynchronous action takes effect as soon as it is asserted and does not wait for the clock. While it is asserted it overrides the clock. After release, the forced value stays until the next enabled clock edge. The mode is meant to be changed only while `rst` is held.

Top module: `acreg_cell`

## Requirements
- R1: With no asynchronous action active, a rising `clk` edge with `ce`=1 makes `q` equal to `d`, and an edge with `ce`=0 leaves `q` unchanged. This holds in every mode, including the modes that invert internally.
- R2: With no asynchronous action active, a rising edge with `rst`=1 makes `q` 0, whatever `ce` and `d` are.
- R3: Mode 3'd1 (clear): while `ac_a` or `ac_b` is 1, `q` is 0 immediately.
- R4: Mode 3'd2 (preset built from the inverted clear path): while `ac_a` is 1, `q` is 1. `ac_b` and `ld_val` have no effect.
- R5: Mode 3'd3 (preset and clear): `ac_a` alone forces `q`=1, `ac_b` forces `q`=0, and `ac_b` wins when both are 1.
- R6: Mode 3'd4 (load with clear): while `ac_a` is 1 and `ac_b` is 0, `q` follows `ld_val` at once, including changes of `ld_val` during the assertion. `ac_b` forces `q`=0 and wins over `ac_a`.
- R7: Mode 3'd5 (load with preset, inverted flop): while `ac_a` is 1 and `ac_b` is 0, `q` follows `ld_val`. `ac_b` forces `q`=1 and wins over `ac_a`.
- R8: Mode 3'd6 (load only): while `ac_a` is 1, `q` follows `ld_val`. `ac_b` has no effect.
- R9: Modes 3'd0 and 3'd7 are a plain register: `ac_a`, `ac_b` and `ld_val` have no effect.
- R10: Clock edges that occur while an asynchronous action is active do not change `q`. After release, `q` keeps the forced value until the next edge with `ce`=1 or `rst`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset (q to 0) |
| mode | input | 3 | Static mode code, see R3 to R9 |
| ce | input | 1 | Clock enable |
| d | input | 1 | Synchronous data |
| ac_a | input | 1 | Shared asynchronous control line A, active high |
| ac_b | input | 1 | Shared asynchronous control line B, active high |
| ld_val | input | 1 | Value loaded asynchronously by the load modes |
| q | output | 1 | Register output |

## Verification
An asynchronous force and a clocked capture can fall into the same cycle. The bench provokes this by raising a control line a few nanoseconds into the low phase and then dropping it two nanoseconds before the next rising edge while `ce`=1. That edge must then capture `d` over the forced value. The bench also changes `ld_val` and releases `ac_b` in the middle of an assertion. A behavioural model built from the mode rules predicts `q` and is compared both after every edge and directly after each mid-cycle change, so a late force, a lost capture or a wrong priority shows up as a mismatch.

// File: rtl/acreg_pkg.sv
package acreg_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_PLAIN   = 3'd0,
    MODE_CLR     = 3'd1,
    MODE_PRE     = 3'd2,
    MODE_PRECLR  = 3'd3,
    MODE_LDCLR   = 3'd4,
    MODE_LDPRE   = 3'd5,
    MODE_LD      = 3'd6,
    MODE_PLAIN_B = 3'd7
  } acreg_mode_e;
endpackage

// File: rtl/acreg_steer.sv
// Maps the two shared control lines and the load value onto the physical
// set/reset pins and picks the data/output inversion for the mode.
module acreg_steer
  import acreg_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic              ac_a,
  input  logic              ac_b,
  input  logic              ld_val,
  output logic              phys_set,
  output logic              phys_clr,
  output logic              inv
);
  acreg_mode_e m;
  assign m = acreg_mode_e'(mode);

  always_comb begin
    phys_set = 1'b0;
    phys_clr = 1'b0;
    inv      = 1'b0;
    case (m)
      MODE_CLR:    phys_clr = ac_a | ac_b;
      MODE_PRE: begin
        inv      = 1'b1;
        phys_clr = ac_a;               // clear of an inverted flop reads as preset
      end
      MODE_PRECLR: begin
        phys_set = ac_a;
        phys_clr = ac_b;
      end
      MODE_LDCLR: begin
        phys_set = ac_a & ld_val;
        phys_clr = (ac_a & ~ld_val) | ac_b;
      end
      MODE_LDPRE: begin
        inv      = 1'b1;               // stored value is the complement
        phys_set = ac_a & ~ld_val;
        phys_clr = (ac_a & ld_val) | ac_b;
      end
      MODE_LD: begin
        phys_set = ac_a & ld_val;
        phys_clr = ac_a & ~ld_val;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acreg_flop.sv
// Physical storage bit: asynchronous reset beats asynchronous set, both beat
// the clock; synchronous reset loads srst_val, then clock enable.
module acreg_flop (
  input  logic clk,
  input  logic srst,
  input  logic srst_val,
  input  logic en,
  input  logic din,
  input  logic aset,
  input  logic aclr,
  output logic qp
);
  logic set_eff;
  // masking set with reset lets set re-fire when reset drops under a held set
  assign set_eff = aset & ~aclr;

  always_ff @(posedge clk or posedge aclr or posedge set_eff) begin
    if (aclr)         qp <= 1'b0;
    else if (set_eff) qp <= 1'b1;
    else if (srst)    qp <= srst_val;
    else if (en)      qp <= din;
  end
endmodule

// File: rtl/acreg_cell.sv
module acreg_cell
  import acreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  input  logic              ce,
  input  logic              d,
  input  logic              ac_a,
  input  logic              ac_b,
  input  logic              ld_val,
  output logic              q
);
  logic phys_set, phys_clr, inv, qp;

  acreg_steer u_steer (
    .mode     (mode),
    .ac_a     (ac_a),
    .ac_b     (ac_b),
    .ld_val   (ld_val),
    .phys_set (phys_set),
    .phys_clr (phys_clr),
    .inv      (inv)
  );

  acreg_flop u_flop (
    .clk      (clk),
    .srst     (rst),
    .srst_val (inv),        // stored complement of 0 when inverted
    .en       (ce),
    .din      (d ^ inv),
    .aset     (phys_set),
    .aclr     (phys_clr),
    .qp       (qp)
  );

  assign q = qp ^ inv;

  logic plain_mode;
  assign plain_mode = (mode == MODE_PLAIN) || (mode == MODE_PLAIN_B);

  // R1
  plain_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (plain_mode && ce) |=> (q == $past(d)));
  // R1
  plain_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (plain_mode && !ce) |=> $stable(q));
  // R3
  clr_force_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode == MODE_CLR) && (ac_a || ac_b)) |-> !q);
  // R4
  pre_force_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode == MODE_PRE) && ac_a) |-> q);
  // R5
  preclr_b_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode == MODE_PRECLR) && ac_b) |-> !q);
  // R5
  preclr_a_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode == MODE_PRECLR) && ac_a && !ac_b) |-> q);
  // R6
  ldclr_load_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode == MODE_LDCLR) && ac_a && !ac_b) |-> (q == ld_val));
  // R6
  ldclr_clr_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode == MODE_LDCLR) && ac_b) |-> !q);
  // R7
  ldpre_load_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode == MODE_LDPRE) && ac_a && !ac_b) |-> (q == ld_val));
  // R7
  ldpre_pre_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode == MODE_LDPRE) && ac_b) |-> q);
  // R8
  ld_load_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode == MODE_LD) && ac_a) |-> (q == ld_val));
endmodule

// File: tb/sim_acreg_cell.sv
module sim_acreg_cell;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] mode = 3'd0;
  logic       ce = 1'b0, d = 1'b0, ac_a = 1'b0, ac_b = 1'b0, ld_val = 1'b0;
  logic       q;

  int    checks = 0;
  int    errors = 0;
  bit    valid = 1'b0;
  bit    done = 1'b0;
  logic  exp_q = 1'b0;
  string tag = "R2";

  acreg_cell u0 (
    .clk(clk), .rst(rst), .mode(mode), .ce(ce), .d(d),
    .ac_a(ac_a), .ac_b(ac_b), .ld_val(ld_val), .q(q)
  );

  always #10 clk = ~clk;   // 50 MHz

  // reference: {active, forced value} from the mode rules
  function automatic logic [1:0] force_of(input logic [2:0] m, input logic a,
                                          input logic b, input logic v);
    case (m)
      3'd1: return (a || b) ? 2'b10 : 2'b00;
      3'd2: return a ? 2'b11 : 2'b00;
      3'd3: return b ? 2'b10 : (a ? 2'b11 : 2'b00);
      3'd4: return b ? 2'b10 : (a ? {1'b1, v} : 2'b00);
      3'd5: return b ? 2'b11 : (a ? {1'b1, v} : 2'b00);
      3'd6: return a ? {1'b1, v} : 2'b00;
      default: return 2'b00;
    endcase
  endfunction

  function automatic string mreq(input logic [2:0] m);
    case (m)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R9";
    endcase
  endfunction

  always @(ac_a, ac_b, ld_val, mode) begin
    logic [1:0] f;
    f = force_of(mode, ac_a, ac_b, ld_val);
    if (f[1]) exp_q = f[0];
  end

  always @(posedge clk) begin
    logic [1:0] f;
    f = force_of(mode, ac_a, ac_b, ld_val);
    if (!f[1]) begin
      if (rst) begin exp_q = 1'b0; valid = 1'b1; end
      else if (ce) exp_q = d;
    end
  end

  task automatic check(input string r);
    checks++;
    if (q !== exp_q) begin
      errors++;
      $display("FAIL %s: q actual %0b expected %0b at %0t", r, q, exp_q, $time);
    end
  endtask

  always begin
    @(posedge clk);
    #5;
    if (valid && !done) check(tag);
  end

  task automatic set_mode(input logic [2:0] m);
    @(negedge clk);
    valid = 1'b0; rst = 1'b1; ac_a = 1'b0; ac_b = 1'b0; ce = 1'b1; d = 1'b1;
    mode = m; tag = "R2";
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R2");   // reset state
  endtask

  task automatic run_mode(input logic [2:0] m);
    string mr;
    mr = mreq(m);
    set_mode(m);
    // synchronous captures and holds
    tag = "R1";
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); d = i[0] ^ i[2]; ce = (i != 3);
    end
    // A with load value 1, mid-cycle assert, value change while held
    @(negedge clk); d = 1'b0; ce = 1'b1; ld_val = 1'b1; #3 ac_a = 1'b1; tag = mr;
    #1 check(mr);
    @(negedge clk); @(negedge clk); ld_val = 1'b0; #1 check(mr);
    @(negedge clk); d = 1'b1; #1 ld_val = 1'b1; #1 check(mr);
    #6 ac_a = 1'b0;  tag = "R1";   // release 2 ns before the capturing edge
    @(negedge clk); d = 1'b0;
    // B alone, then hold after release with ce low
    @(negedge clk); ce = 1'b0; d = 1'b1; #3 ac_b = 1'b1; tag = mr;
    #1 check(mr);
    @(negedge clk); @(negedge clk); #8 ac_b = 1'b0; tag = "R10";
    repeat (2) @(negedge clk);
    // both lines, then B released while A held, ld_val 0 then 1
    for (int v = 0; v < 2; v++) begin
      @(negedge clk); ce = 1'b1; d = ~v[0]; ld_val = v[0]; tag = "R10";
      #2 ac_a = 1'b1; #2 ac_b = 1'b1; #1 check(mr);
      @(negedge clk); #4 ac_b = 1'b0; #1 check(mr);
      @(negedge clk); #1 check(mr);
      #7 ac_a = 1'b0; tag = "R1";
      @(negedge clk); ce = 1'b0;
    end
    // B pulse inside one cycle, clock edge while held
    @(negedge clk); ce = 1'b1; d = 1'b1; #2 ac_b = 1'b1; tag = "R10";
    @(negedge clk); d = 1'b0; #1 check("R10");
    #3 ac_b = 1'b0; tag = "R1";
    @(negedge clk);
    // synchronous reset over an enabled capture
    @(negedge clk); ce = 1'b1; d = 1'b1;
    @(negedge clk); rst = 1'b1; tag = "R2";
    @(negedge clk); rst = 1'b0; tag = "R1";
    @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    for (int m = 0; m < 8; m++) run_mode(m[2:0]);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual still running, expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule